// File: doc/BRIEF.md
# Timer Count-Enable Front End

This block sits in front of an 8-bit timer/counter and decides when the counter may advance. It turns one of two sources into a single-cycle count-enable strobe. The first source is the internal clock divided by 1, 8, 64, 256 or 1024, with the taps taken from a free-running 10-bit prescaler counter. The second is an external pin. The pin is never used as a clock: it is sampled by a two-flop synchronizer and then passed through an edge detector, so each selected edge becomes exactly one enable. The external path bypasses the prescaler and is never divided.

A small control register holds two active bits. The first clears the prescaler. The second is a hold bit that makes the clear sticky, so software can keep the timer frozen while it sets the timer up. Once the hold bit is written back to zero, the clear drops and counting restarts from a freshly cleared prescaler. A correctly detected external clock must run below half the system clock, and each of its half-periods must be longer than one system clock cycle.

Top module: `tmr_clk_front`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 and `cnt_en` is low.
- R2: Register layout: bit 7 is the hold bit and bit 0 is the prescaler-clear bit. Bits 6..1 ignore writes and always read 0.
- R3: Writing a value with bit 0 = 1 and bit 7 = 0 makes bit 0 read 1 for exactly one cycle. Hardware then clears it.
- R4: While the hold bit is 1, a written clear bit of 1 stays set and `cnt_en` stays low for every `clk_sel` source, external edges included.
- R5: Writing 0x00 while held releases the clear. For ratio N, the first enable is seen N cycles after the release write edge.
- R6: `clk_sel` = 0 (stopped) produces no enables.
- R7: `clk_sel` values 1..5 select divide ratios 1, 8, 64, 256 and 1024, and enables are spaced exactly N cycles apart.
- R8: After a one-shot prescaler clear (write 0x01), the first enable is seen N+1 cycles after the write edge.
- R9: `clk_sel` = 7 gives one enable per rising pin edge, three clock edges after the pin change is sampled.
- R10: `clk_sel` = 6 gives one enable per falling pin edge, with the same latency.
- R11: External enables are one cycle wide, and every pin edge is counted exactly once, with no division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| clk_sel | input | 3 | Source select: 0 stopped, 1..5 divided, 6 pin falling, 7 pin rising |
| ext_pin | input | 1 | Asynchronous external clock pin |
| cnt_en | output | 1 | One-cycle count-enable strobe to the timer |

## Verification
Assertions check four things on every cycle: the clear bit self-clears when no hold is set, a held clear persists, the prescaler counter is zero after a clear, and no enable appears after a cycle spent in clear or with the stopped selection. They also check that the edge detector never flags both directions at once and never emits back-to-back pulses. Only the bench scenarios can show the exact enable spacing for each ratio, where the first enable lands after a one-shot clear and after a hold release, and that a random external waveform yields exactly one enable per chosen edge at the stated latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_D1       = 3'd1,
    SEL_D8       = 3'd2,
    SEL_D64      = 3'd3,
    SEL_D256     = 3'd4,
    SEL_D1024    = 3'd5,
    SEL_EXT_FALL = 3'd6,
    SEL_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam int NUM_TAPS = 5;
  localparam int HOLD_BIT = 7;
  localparam int CLR_BIT  = 0;

  // log2 of the division ratio for tap index 0..NUM_TAPS-1
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       clr_o,
  output logic       hold_o
);

  logic clr_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (wr_en) begin
      hold_q <= wr_data[HOLD_BIT];
      clr_q  <= wr_data[CLR_BIT];
    end else if (!hold_q) begin
      clr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data           = 8'h00;
    rd_data[HOLD_BIT] = hold_q;
    rd_data[CLR_BIT]  = clr_q;
  end

  assign clr_o  = clr_q;
  assign hold_o = hold_q;

  // R3: a clear without hold drops after one cycle
  a_r3_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !hold_q && !wr_en) |=> !clr_q);

  // R3: writing the clear bit sets it
  a_r3_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CLR_BIT]) |=> clr_q);

  // R4: under hold the clear is kept
  a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && clr_q && !wr_en) |=> clr_q);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  output logic [NUM_TAPS-1:0] tap_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  // each tap fires on the last count before its low bits wrap to zero
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << tap_shift(g)) - 64'd1);
    assign tap_o[g] = ((cnt_q & MASK) == MASK) && !clr;
  end

  // R8: a clear leaves the counter at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], pin};
  end

  logic cur_s;
  logic prev_s;
  assign cur_s  = chain_q[LAST-1];
  assign prev_s = chain_q[LAST];
  assign rise_o = cur_s & ~prev_s;
  assign fall_o = ~cur_s & prev_s;

  // R11: never both directions at once, never two pulses in a row
  a_r11_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));
  a_r11_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r11_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_clk_front.sv
module tmr_clk_front
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [2:0] clk_sel,
  input  logic       ext_pin,
  output logic       cnt_en
);

  logic                clr_s;
  logic                hold_s;
  logic [NUM_TAPS-1:0] taps_s;
  logic                rise_s;
  logic                fall_s;
  logic                src_tick;
  logic                cnt_en_q;

  tmr_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .rd_data (reg_rdata),
    .clr_o   (clr_s),
    .hold_o  (hold_s)
  );

  tmr_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_s),
    .tap_o (taps_s)
  );

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (ext_pin),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  always_comb begin
    case (clk_sel_e'(clk_sel))
      SEL_D1:       src_tick = taps_s[0];
      SEL_D8:       src_tick = taps_s[1];
      SEL_D64:      src_tick = taps_s[2];
      SEL_D256:     src_tick = taps_s[3];
      SEL_D1024:    src_tick = taps_s[4];
      SEL_EXT_FALL: src_tick = fall_s;
      SEL_EXT_RISE: src_tick = rise_s;
      default:      src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_en_q <= 1'b0;
    else        cnt_en_q <= src_tick & ~clr_s;
  end

  assign cnt_en = cnt_en_q;

  // R4: a cycle spent in clear yields no enable
  a_r4_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> !cnt_en);

  // R6: stopped selection yields no enable
  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |=> !cnt_en);

  // R11: external rising enables are single-cycle
  a_r11_ext_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd7 && cnt_en) |=> !cnt_en);

endmodule

// File: tb/tmr_clk_front_test.sv
module tmr_clk_front_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] clk_sel = 3'd0;
  logic       ext_pin = 1'b0;
  logic       cnt_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_clk_front uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_sel   (clk_sel),
    .ext_pin   (ext_pin),
    .cnt_en    (cnt_en)
  );

  function automatic int ratio_of(input int sel);
    int r = 1;
    for (int i = 1; i < sel; i++) r = r * ((i == 3) ? 4 : 8);
    if (sel == 5) r = 1024;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // R7, R8: one-shot clear then enable spacing
  task automatic div_test(input int sel);
    int n = ratio_of(sel);
    int first = -1;
    int gap;
    clk_sel = 3'(sel);
    wr(8'h01);
    chk(reg_rdata == 8'h01, "R3", reg_rdata, 1);
    for (int k = 1; k <= n + 4; k++) begin
      @(negedge clk);
      if (k == 1) chk(reg_rdata == 8'h00, "R3", reg_rdata, 0);
      if (cnt_en && first < 0) first = k;
      if (first >= 0) break;
    end
    chk(first == n + 1, "R8", first, n + 1);
    for (int rep = 0; rep < 2; rep++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!cnt_en && gap < 2000);
      chk(gap == n, "R7", gap, n);
    end
  endtask

  // R4, R5: hold then release
  task automatic hold_test(input int sel, input int wait_cyc);
    int n = ratio_of(sel);
    int first = -1;
    int bad = 0;
    clk_sel = 3'(sel);
    wr(8'h81);
    for (int k = 0; k < wait_cyc; k++) begin
      @(negedge clk);
      if (cnt_en) bad++;
    end
    chk(bad == 0, "R4", bad, 0);
    chk(reg_rdata == 8'h81, "R4", reg_rdata, 8'h81);
    wr(8'h00);
    chk(reg_rdata == 8'h00, "R5", reg_rdata, 0);
    for (int k = 1; k <= n + 4; k++) begin
      @(negedge clk);
      if (cnt_en) begin
        first = k;
        break;
      end
    end
    chk(first == n, "R5", first, n);
  endtask

  // R9, R10, R11: random pin waveform, per-cycle comparison
  task automatic ext_test(input bit rising, input int cycles);
    logic hist [0:3];
    int edges = 0;
    int pulses = 0;
    int mism = 0;
    int run = 0;
    logic exp_en;
    clk_sel = rising ? 3'd7 : 3'd6;
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) hist[i] = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      exp_en = rising ? (hist[2] & ~hist[3]) : (~hist[2] & hist[3]);
      if (cnt_en !== exp_en) mism++;
      if (cnt_en) pulses++;
      if (exp_en) edges++;
      if (run == 0) begin
        ext_pin = ~ext_pin;
        run = 2 + int'($urandom_range(3));
      end
      run--;
      hist[3] = hist[2];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = ext_pin;
    end
    chk(mism == 0, rising ? "R9" : "R10", mism, 0);
    chk(pulses == edges && edges > 10, "R11", pulses, edges);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1", reg_rdata, 0);
    chk(cnt_en == 1'b0, "R1", cnt_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reserved bits ignored, layout
    wr(8'hFE);
    chk(reg_rdata == 8'h80, "R2", reg_rdata, 8'h80);
    wr(8'h7F);
    chk(reg_rdata == 8'h01, "R2", reg_rdata, 8'h01);
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R3", reg_rdata, 0);

    // R6: stopped
    begin
      int seen = 0;
      clk_sel = 3'd0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (cnt_en) seen++;
      end
      chk(seen == 0, "R6", seen, 0);
    end

    for (int s = 1; s <= 5; s++) div_test(s);

    hold_test(2, 20);
    hold_test(1, 5);
    for (int i = 0; i < 6; i++)
      hold_test(1 + int'($urandom_range(3)), 3 + int'($urandom_range(60)));

    ext_test(1'b1, 400);
    ext_test(1'b0, 400);

    // R4: external edges under hold are dropped
    begin
      int seen = 0;
      clk_sel = 3'd7;
      wr(8'h81);
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (cnt_en) seen++;
        if (k % 3 == 0) ext_pin = ~ext_pin;
      end
      chk(seen == 0, "R4", seen, 0);
      wr(8'h00);
    end
    ext_pin = 1'b0;
    ext_test(1'b1, 200);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule